// File: doc/BRIEF.md
# Bidirectional Sweep Read-Address Generator

This block produces the word addresses for a stereo sample memory that is written in real time and read back in a back-and-forth sweep. A write pointer walks circularly through the memory, two words per sample period (left word, then right word). The read address is the write address minus an offset. The offset shrinks while playback runs forward at twice real-time speed. It grows while playback runs backward at real-time speed. A direction flag flips each time the offset meets either end of a programmable buffer length.

After reset the block first walks every memory address once, driving a write enable so that the surrounding logic can store zeros. It then raises a ready flag and begins following the per-sample strobe. All updates for a sample period happen in the single clock cycle of the strobe. Between strobes every address output holds its value. The per-sample strobe and the buffer length are plain control inputs, with no handshake.

Top module: `sweep_addr_gen`

## Requirements
- R1: While reset is asserted, `ready` is 0, `clr_we` is 1, `clr_addr` is 0, `reverse` is 0, `wr_addr_l` is 0, and `rd_addr_l` equals 0 minus MIN_LEN modulo 2^ADDR_W. The internal offset starts at MIN_LEN.
- R2: After reset, `clr_we` stays 1 for exactly 2^ADDR_W cycles while `clr_addr` counts 0, 1, … 2^ADDR_W−1, one step per clock. Then `ready` becomes 1 and `clr_we` becomes 0, and both stay that way until the next reset.
- R3: A `sample_stb` that arrives while `ready` is 0 changes no write address, read address or direction output.
- R4: Each accepted strobe advances `wr_addr_l` by 2 modulo 2^ADDR_W. At all times `wr_addr_r` equals `wr_addr_l` + 1 modulo 2^ADDR_W.
- R5: After each strobe, `rd_addr_l` equals the new `wr_addr_l` minus the new offset, taken modulo 2^ADDR_W. At all times `rd_addr_r` equals `rd_addr_l` + 1 modulo 2^ADDR_W.
- R6: In forward mode (`reverse` = 0), when subtracting 2 from the offset does not give zero, an accepted strobe lowers the offset by 2. The read address then moves ahead by 4 words.
- R7: In forward mode, when subtracting 2 would make the offset zero, the offset is set to 4 and `reverse` becomes 1. This replays the last frame.
- R8: In reverse mode, when the offset plus 4 (modulo 2^OFS_W) is below `buf_len`, an accepted strobe sets the offset to that sum. `reverse` stays 1, and the read address moves back by 2 words.
- R9: In reverse mode, when the offset plus 4 is not below `buf_len`, `reverse` becomes 0 and the offset becomes the old offset plus 2. This holds playback on one frame. If that sum is zero, R7 applies instead.
- R10: With no accepted strobe, every write address, read address and `reverse` output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | One-cycle pulse per sample period |
| buf_len | input | OFS_W | Buffer length, unsigned, in words |
| ready | output | 1 | Clearing finished; strobes are accepted |
| clr_we | output | 1 | Zero-write enable during clearing |
| clr_addr | output | ADDR_W | Address being cleared |
| wr_addr_l | output | ADDR_W | Left-word write address |
| wr_addr_r | output | ADDR_W | Right-word write address |
| rd_addr_l | output | ADDR_W | Left-word read address |
| rd_addr_r | output | ADDR_W | Right-word read address |
| reverse | output | 1 | 1 while playback sweeps backward |

## Verification
The assertions assume that `sample_stb` and `buf_len` are stable around each rising edge. They also assume the offset stays even, so that the offset reaches exactly zero during a forward sweep. That holds when `buf_len` is a multiple of 4, because the reset offset and every step are even.

The bench drives `sample_stb` and `buf_len` on falling edges and uses only lengths that are multiples of 4. It raises and shortens the length while a sweep is running, including a drop below the current offset, and one length that exceeds the address space.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } sweep_dir_e;

  localparam int unsigned FWD_STEP  = 2;
  localparam int unsigned REV_STEP  = 4;
  localparam int unsigned TURN_OFS  = 4;
  localparam int unsigned WORDS_PER = 2;

endpackage

// File: rtl/sweep_clear_seq.sv
module sweep_clear_seq #(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              ready,
  output logic              clr_we,
  output logic [ADDR_W-1:0] clr_addr
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  logic [ADDR_W-1:0] cnt_q;
  logic              done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + ADDR_W'(1);
      end
    end
  end

  assign ready    = done_q;
  assign clr_we   = !done_q;
  assign clr_addr = cnt_q;

  // R2
  clr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_q && cnt_q != LAST) |=> (!done_q && cnt_q == $past(cnt_q) + ADDR_W'(1)));
  // R2
  clr_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_q && cnt_q == LAST) |=> done_q);
  // R2
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);
endmodule

// File: rtl/sweep_write_ptr.sv
module sweep_write_ptr
  import sweep_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output logic [ADDR_W-1:0] wr_l,
  output logic [ADDR_W-1:0] wr_r,
  output logic [ADDR_W-1:0] wr_nxt
);
  logic [ADDR_W-1:0] wr_q;

  assign wr_nxt = wr_q + ADDR_W'(WORDS_PER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  wr_q <= '0;
    else if (go) wr_q <= wr_nxt;
  end

  assign wr_l = wr_q;
  assign wr_r = wr_q + ADDR_W'(1);

  // R4
  wr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> wr_q == $past(wr_q) + ADDR_W'(2));
  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(wr_q));
endmodule

// File: rtl/sweep_offset.sv
module sweep_offset
  import sweep_pkg::*;
#(
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned OFS_W   = 24,
  parameter int unsigned MIN_LEN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [OFS_W-1:0]  len,
  output logic              rev,
  output logic [ADDR_W-1:0] ofs_lo,
  output logic [ADDR_W-1:0] ofs_lo_nxt
);
  sweep_dir_e        dir_q, dir_d;
  logic [OFS_W-1:0]  ofs_q, ofs_d;
  logic [OFS_W-1:0]  grown, shrink_src, shrunk;
  logic              keep_rev;

  always_comb begin
    grown      = ofs_q + OFS_W'(REV_STEP);
    keep_rev   = (dir_q == DIR_REV) && (grown < len);
    shrink_src = (dir_q == DIR_REV) ? grown : ofs_q;
    shrunk     = shrink_src - OFS_W'(FWD_STEP);
    if (keep_rev) begin
      ofs_d = grown;
      dir_d = DIR_REV;
    end else if (shrunk == '0) begin
      ofs_d = OFS_W'(TURN_OFS);
      dir_d = DIR_REV;
    end else begin
      ofs_d = shrunk;
      dir_d = DIR_FWD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= OFS_W'(MIN_LEN);
      dir_q <= DIR_FWD;
    end else if (go) begin
      ofs_q <= ofs_d;
      dir_q <= dir_d;
    end
  end

  assign rev        = (dir_q == DIR_REV);
  assign ofs_lo     = ofs_q[ADDR_W-1:0];
  assign ofs_lo_nxt = ofs_d[ADDR_W-1:0];

  // R6
  fwd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && dir_q == DIR_FWD && ofs_q != OFS_W'(2))
      |=> (dir_q == DIR_FWD && ofs_q == $past(ofs_q) - OFS_W'(2)));
  // R7
  fwd_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && dir_q == DIR_FWD && ofs_q == OFS_W'(2))
      |=> (dir_q == DIR_REV && ofs_q == OFS_W'(4)));
  // R8
  rev_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && dir_q == DIR_REV && (ofs_q + OFS_W'(4)) < len)
      |=> (dir_q == DIR_REV && ofs_q == $past(ofs_q) + OFS_W'(4)));
  // R9
  rev_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && dir_q == DIR_REV && !((ofs_q + OFS_W'(4)) < len) && (ofs_q + OFS_W'(2)) != '0)
      |=> (dir_q == DIR_FWD && ofs_q == $past(ofs_q) + OFS_W'(2)));
  // R10
  ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> ($stable(ofs_q) && $stable(dir_q)));
endmodule

// File: rtl/sweep_addr_gen.sv
module sweep_addr_gen #(
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned OFS_W   = 24,
  parameter int unsigned MIN_LEN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_stb,
  input  logic [OFS_W-1:0]  buf_len,
  output logic              ready,
  output logic              clr_we,
  output logic [ADDR_W-1:0] clr_addr,
  output logic [ADDR_W-1:0] wr_addr_l,
  output logic [ADDR_W-1:0] wr_addr_r,
  output logic [ADDR_W-1:0] rd_addr_l,
  output logic [ADDR_W-1:0] rd_addr_r,
  output logic              reverse
);
  localparam logic [ADDR_W-1:0] RD_RST = ADDR_W'(0) - ADDR_W'(MIN_LEN);

  logic              go;
  logic [ADDR_W-1:0] wr_nxt, ofs_lo, ofs_lo_nxt;
  logic [ADDR_W-1:0] rd_q;

  sweep_clear_seq #(.ADDR_W(ADDR_W)) u_clear (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready),
    .clr_we   (clr_we),
    .clr_addr (clr_addr)
  );

  assign go = sample_stb && ready;

  sweep_write_ptr #(.ADDR_W(ADDR_W)) u_wr (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go),
    .wr_l   (wr_addr_l),
    .wr_r   (wr_addr_r),
    .wr_nxt (wr_nxt)
  );

  sweep_offset #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .MIN_LEN(MIN_LEN)) u_ofs (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .len        (buf_len),
    .rev        (reverse),
    .ofs_lo     (ofs_lo),
    .ofs_lo_nxt (ofs_lo_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rd_q <= RD_RST;
    else if (go) rd_q <= wr_nxt - ofs_lo_nxt;
  end

  assign rd_addr_l = rd_q;
  assign rd_addr_r = rd_q + ADDR_W'(1);

  // R5
  rd_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_l == wr_addr_l - ofs_lo);
  // R3
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ($stable(wr_addr_l) && $stable(rd_addr_l) && $stable(reverse)));
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(rd_q));
endmodule

// File: tb/tb_sweep_addr_gen.sv
module tb_sweep_addr_gen;
  localparam int AW  = 10;
  localparam int OW  = 24;
  localparam int MIN = 256;
  localparam int N   = 1 << AW;
  localparam int M24 = (1 << OW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sample_stb = 1'b0;
  logic [OW-1:0] buf_len = OW'(256);
  logic          ready, clr_we, reverse;
  logic [AW-1:0] clr_addr, wr_addr_l, wr_addr_r, rd_addr_l, rd_addr_r;

  int tests = 0;
  int fails = 0;

  // behavioural reference state
  int m_wr, m_ofs, m_rev, m_cnt, m_rdy, m_rd;

  always #5 clk = ~clk;

  sweep_addr_gen #(.ADDR_W(AW), .OFS_W(OW), .MIN_LEN(MIN)) dut (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .buf_len(buf_len),
    .ready(ready), .clr_we(clr_we), .clr_addr(clr_addr),
    .wr_addr_l(wr_addr_l), .wr_addr_r(wr_addr_r),
    .rd_addr_l(rd_addr_l), .rd_addr_r(rd_addr_r), .reverse(reverse)
  );

  task automatic model_reset();
    m_wr = 0; m_ofs = MIN; m_rev = 0; m_cnt = 0; m_rdy = 0;
    m_rd = (0 - MIN) & (N - 1);                       // R1
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else if (!m_rdy) begin                            // R2 clearing, R3 strobe ignored
      if (m_cnt == N - 1) begin m_rdy = 1; m_cnt = 0; end
      else m_cnt = m_cnt + 1;
    end else if (sample_stb) begin
      int up, src, dn;
      m_wr = (m_wr + 2) & (N - 1);                    // R4
      up = (m_ofs + 4) & M24;
      if (m_rev == 1 && up < int'(buf_len)) m_ofs = up; // R8
      else begin
        src = (m_rev == 1) ? up : m_ofs;              // R9 holds one frame
        dn  = (src - 2) & M24;                        // R6
        if (dn == 0) begin m_ofs = 4; m_rev = 1; end  // R7
        else begin m_ofs = dn; m_rev = 0; end
      end
      m_rd = (m_wr - m_ofs) & (N - 1);                // R5
    end
    // no accepted strobe: all state held (R10)
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    check({tag, " R2 ready"},    int'(ready),     m_rdy);
    check({tag, " R2 clr_we"},   int'(clr_we),    1 - m_rdy);
    check({tag, " R2 clr_addr"}, int'(clr_addr),  m_cnt);
    check({tag, " R4 wr_l"},     int'(wr_addr_l), m_wr);
    check({tag, " R4 wr_r"},     int'(wr_addr_r), (m_wr + 1) & (N - 1));
    check({tag, " R5 rd_l"},     int'(rd_addr_l), m_rd);
    check({tag, " R5 rd_r"},     int'(rd_addr_r), (m_rd + 1) & (N - 1));
    check({tag, " R7 R9 reverse"}, int'(reverse), m_rev);
  endtask

  task automatic run(input string tag, input int cycles, input int period);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compare_all(tag);
      sample_stb = (period > 0) && ((i % period) == 0);
    end
  endtask

  initial begin
    sample_stb = 1'b1;
    repeat (3) @(negedge clk);
    compare_all("R1 reset");
    rst_n = 1'b1;
    run("R3 clearing", N + 10, 2);                    // strobes during clearing ignored
    run("R6 R7 R8 R9 len256", 420, 1);
    buf_len = OW'(40);
    run("R10 sparse len40", 300, 3);
    buf_len = OW'(2048);                              // larger than address space
    run("R5 wrap len2048", 1200, 1);
    buf_len = OW'(8);                                 // shrink mid-sweep
    run("R9 shrink len8", 60, 1);
    run("R10 idle", 20, 0);
    buf_len = OW'(64);
    run("R8 len64", 100, 2);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule